// File: doc/BRIEF.md
# Asynchronous serial receiver with mute and idle-line wake-up

This block receives asynchronous serial characters on a single line. Each character has one start bit (0), eight data bits sent least significant bit first, and one stop bit (1). An oversampling tick arrives sixteen times per bit period. When the receiver is switched on it waits for a falling line. It takes three samples in the middle of every bit and decides the bit by majority vote. Each finished character is moved from the shift register into a data register that the host reads over a small register port.

Software can put the receiver into a muted state. While muted, finished characters are thrown away and no flag changes. Hardware ends the muted state by itself when the line has stayed high for a whole frame time after some activity, but only if at least one character was received while the receiver was active. If no character has ever been received, only software can end the muted state.

The data path is register-based, and a full-flag handshake provides the back-pressure. A loaded character stays in the data register until the host reads it. A character that completes while the data register is still full is dropped, and the overrun flag is raised instead. Control and status stay as plain register fields.

Top module: `uart_mute_rx`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 2) both read 0.
- R2: While the enable bit (control bit 0) is 0, the receiver ignores traffic on the line, and no status flag changes.
- R3: Each bit is decided by a majority of the samples taken at oversampling ticks 8, 9 and 10 of the bit. A one-tick glitch inside the sample window does not change the bit. A low pulse that does not hold low across the start bit's sample window is rejected, and no character results.
- R4: Data bits arrive least significant bit first. In active mode, a completed character is written to the data register (address 1) and sets the full flag (status bit 0). Reading address 1 with the read strobe clears status bits 0, 1 and 2.
- R5: If the full flag is still set when another character completes, the overrun flag (status bit 1) is set and the data register keeps the older character.
- R6: A character whose stop bit is decided as 0 sets the framing-error flag (status bit 2) when it loads. A character with a good stop bit loads with that flag at 0.
- R7: While the mute bit (control bit 1) is 1, completed characters change neither the data register nor any status flag.
- R8: While muted, and provided a character was received in active mode beforehand, 160 consecutive ticks of high line (ten bit times) clear the mute bit in hardware.
- R9: If no character has been received in active mode since reset, an idle line never clears the mute bit.
- R10: Software writes to the control register set and clear the enable and mute bits directly. After software clears the mute bit, characters load again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling strobe, sixteen per bit period |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a read of address 1 clears flags) |
| reg_addr_i | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wdata_i | input | 8 | Write data (control: bit 0 enable, bit 1 mute) |
| reg_rdata_o | output | 8 | Combinational read data for reg_addr_i |

## Verification
The line passes through a two-flop synchronizer before it is sampled. A character therefore completes in the clock that follows the sixteenth tick of its stop bit, with up to one tick period of extra delay. Its flags can be read one clock after that. The bench waits two full tick periods after the last stop-bit tick before it reads status or data. Register reads are combinational and are sampled one nanosecond after the address is driven on a falling edge. The idle wake-up falls roughly 160 ticks after the last low bit. The bench therefore reads the mute bit once well inside that window (expecting it still set) and once well past it (expecting it cleared), so a one-tick phase uncertainty cannot flip either result.

// File: rtl/uart_mute_rx_pkg.sv
package uart_mute_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // two-of-three decision
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

endpackage

// File: rtl/rxm_sync.sv
module rxm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d_i};
  end

  assign q_o = sh[STAGES-1];
endmodule

// File: rtl/rxm_frame.sv
// Frame engine: start search, mid-bit majority sampling, deserialization.
// OVS must be a power of two so the tick counter wraps per bit.
module rxm_frame
  import uart_mute_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             rx_i,
  output logic             done_o,
  output logic             stop_ok_o,
  output logic [DBITS-1:0] data_o
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DBITS + 1);
  localparam int SMP0 = OVS / 2 - 1;

  rx_state_e       st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitn;
  logic [2:0]      smp;
  logic            bit_v;

  assign bit_v = vote3(smp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      smp       <= '1;
      data_o    <= '0;
      done_o    <= 1'b0;
      stop_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        st <= ST_IDLE;
      end else if (tick_i) begin
        if (st == ST_IDLE) begin
          if (!rx_i) begin
            st  <= ST_START;
            cnt <= CW'(1);
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(SMP0))     smp[0] <= rx_i;
          if (cnt == CW'(SMP0 + 1)) smp[1] <= rx_i;
          if (cnt == CW'(SMP0 + 2)) smp[2] <= rx_i;
          if (cnt == CW'(OVS - 1)) begin
            case (st)
              ST_START: begin
                if (bit_v) st <= ST_IDLE;
                else begin
                  st   <= ST_DATA;
                  bitn <= '0;
                end
              end
              ST_DATA: begin
                data_o <= {bit_v, data_o[DBITS-1:1]};
                bitn   <= bitn + 1'b1;
                if (bitn == BW'(DBITS - 1)) st <= ST_STOP;
              end
              default: begin
                st        <= ST_IDLE;
                done_o    <= 1'b1;
                stop_ok_o <= bit_v;
              end
            endcase
          end
        end
      end
    end
  end

  // R2: a disabled receiver sits in its idle state and completes nothing
  a_r2_halt_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st == ST_IDLE) && !done_o);

  // R3: a start bit is never accepted outside the end of its bit period
  a_r3_start_decided_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START) && en_i && tick_i && (cnt != CW'(OVS - 1)) |=> (st == ST_START));
endmodule

// File: rtl/rxm_idle.sv
// Idle detector: one pulse after a full frame of continuous high line.
module rxm_idle #(
  parameter int OVS        = 16,
  parameter int FRAME_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic rx_i,
  output logic idle_o
);
  localparam int LIMIT = OVS * FRAME_BITS;
  localparam int W     = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;
  logic         fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      fired  <= 1'b0;
      idle_o <= 1'b0;
    end else begin
      idle_o <= 1'b0;
      if (!en_i || !rx_i) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (tick_i && !fired) begin
        cnt <= cnt + 1'b1;
        if (cnt == W'(LIMIT - 1)) begin
          fired  <= 1'b1;
          idle_o <= 1'b1;
        end
      end
    end
  end

  // R8: the idle pulse only follows a high line
  a_r8_idle_on_high_line: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> $past(rx_i) && $past(en_i));
endmodule

// File: rtl/uart_mute_rx.sv
module uart_mute_rx
  import uart_mute_rx_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int DBITS      = 8,
  parameter int FRAME_BITS = DBITS + 2,
  parameter int SYNC       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  logic             rx_s;
  logic             done;
  logic             stop_ok;
  logic [DBITS-1:0] rxd;
  logic             idle_p;

  logic             on_q, mute_q, got_q;
  logic [DBITS-1:0] data_q;
  logic             full_q, ovr_q, ferr_q;
  logic             wr_ctrl, rd_data;
  logic             unused_wdata;

  assign wr_ctrl      = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign rd_data      = reg_rd_i && (reg_addr_i == ADDR_DATA);
  assign unused_wdata = ^reg_wdata_i[7:2];

  rxm_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  rxm_frame #(.OVS(OVS), .DBITS(DBITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .en_i(on_q), .tick_i(tick_i), .rx_i(rx_s),
    .done_o(done), .stop_ok_o(stop_ok), .data_o(rxd)
  );

  rxm_idle #(.OVS(OVS), .FRAME_BITS(FRAME_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .en_i(on_q), .tick_i(tick_i), .rx_i(rx_s),
    .idle_o(idle_p)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      mute_q <= 1'b0;
      got_q  <= 1'b0;
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (rd_data) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
        ferr_q <= 1'b0;
      end
      if (done && !mute_q) begin
        got_q <= 1'b1;
        if (full_q && !rd_data) begin
          ovr_q <= 1'b1;
        end else begin
          data_q <= rxd;
          full_q <= 1'b1;
          ferr_q <= !stop_ok;
        end
      end
      if (mute_q && idle_p && got_q) mute_q <= 1'b0;
      if (wr_ctrl) begin
        on_q   <= reg_wdata_i[0];
        mute_q <= reg_wdata_i[1];
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {6'd0, mute_q, on_q};
      ADDR_DATA: reg_rdata_o = 8'(data_q);
      ADDR_STAT: reg_rdata_o = {5'd0, ferr_q, ovr_q, full_q};
      default:   reg_rdata_o = 8'd0;
    endcase
  end

  // R4: an active-mode completion into an empty register loads it
  a_r4_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mute_q && !full_q |=> full_q && (data_q == $past(rxd)));

  // R5: completion against a full register keeps the old character
  a_r5_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mute_q && full_q && !rd_data |=> ovr_q && $stable(data_q));

  // R7: muted completions leave data and flags untouched
  a_r7_mute_silent: assert property (@(posedge clk) disable iff (!rst_n)
    done && mute_q && !rd_data |=> $stable({full_q, ovr_q, ferr_q, data_q}));

  // R9: without a prior character the mute bit holds
  a_r9_no_wake_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    mute_q && !got_q && !wr_ctrl |=> mute_q);

  // R8: an armed idle detection ends mute mode
  a_r8_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mute_q && got_q && idle_p && !wr_ctrl |=> !mute_q);
endmodule

// File: tb/test_uart_mute_rx.sv
`timescale 1ns/1ps
module test_uart_mute_rx;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  int         checks = 0, failures = 0;
  bit         finished = 1'b0;

  // {byte, stop bit value, glitch in bit 3}
  localparam logic [9:0] VEC [6] = '{
    {8'hA5, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b0},
    {8'h3C, 1'b1, 1'b1},
    {8'h81, 1'b0, 1'b0},
    {8'h5A, 1'b1, 1'b1}
  };

  uart_mute_rx i_uart_mute_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    rd   = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    addr  = a;
    wdata = v;
    wr    = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic stop, input logic glitch);
    @(negedge clk);
    rx = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      if (glitch && i == 3) begin
        wait_ticks(8);
        rx = ~d[i];
        wait_ticks(1);
        rx = d[i];
        wait_ticks(7);
      end else begin
        wait_ticks(16);
      end
    end
    rx = stop;
    wait_ticks(16);
    rx = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    logic [9:0] e;
    do_reset();

    // R1 reset state
    reg_read(2'd0, v); check("R1 ctrl", v, 8'h00);
    reg_read(2'd2, v); check("R1 status", v, 8'h00);

    // R2 disabled receiver ignores a frame
    send(8'h33, 1'b1, 1'b0);
    wait_ticks(2);
    reg_read(2'd2, v); check("R2 status while off", v, 8'h00);

    reg_write(2'd0, 8'h01);
    reg_read(2'd0, v); check("R10 enable written", v, 8'h01);
    wait_ticks(4);

    // table walk: R3 glitches, R4 loading and clear, R6 stop errors
    for (int i = 0; i < 6; i++) begin
      e = VEC[i];
      send(e[9:2], e[1], e[0]);
      wait_ticks(2);
      reg_read(2'd2, v); check("R6 status after load", v, {5'd0, ~e[1], 1'b0, 1'b1});
      reg_read(2'd1, v); check(e[0] ? "R3 glitched data" : "R4 data", v, e[9:2]);
      reg_read(2'd2, v); check("R4 read clears flags", v, 8'h00);
    end

    // R3 short low pulse rejected as noise
    @(negedge clk); rx = 1'b0;
    wait_ticks(3);
    rx = 1'b1;
    wait_ticks(30);
    reg_read(2'd2, v); check("R3 noise start rejected", v, 8'h00);
    send(8'h96, 1'b1, 1'b0);
    wait_ticks(2);
    reg_read(2'd1, v); check("R3 resync after noise", v, 8'h96);

    // R5 overrun
    send(8'h11, 1'b1, 1'b0);
    wait_ticks(2);
    send(8'h22, 1'b1, 1'b0);
    wait_ticks(2);
    reg_read(2'd2, v); check("R5 overrun status", v, 8'h03);
    reg_read(2'd1, v); check("R5 older data kept", v, 8'h11);

    // R7 / R8 mute with an armed wake-up
    reg_write(2'd0, 8'h03);
    reg_read(2'd0, v); check("R10 mute written", v, 8'h03);
    send(8'h55, 1'b1, 1'b0);
    wait_ticks(2);
    reg_read(2'd2, v); check("R7 no flags in mute", v, 8'h00);
    reg_read(2'd1, v); check("R7 data not loaded", v, 8'h11);
    wait_ticks(116);
    reg_read(2'd0, v); check("R8 still muted before idle", v, 8'h03);
    wait_ticks(50);
    reg_read(2'd0, v); check("R8 idle wake clears mute", v, 8'h01);

    // R9 / R10 mute with no prior character
    do_reset();
    reg_write(2'd0, 8'h03);
    send(8'h77, 1'b1, 1'b0);
    wait_ticks(200);
    reg_read(2'd0, v); check("R9 stays muted", v, 8'h03);
    reg_read(2'd2, v); check("R9 status quiet", v, 8'h00);
    reg_write(2'd0, 8'h01);
    reg_read(2'd0, v); check("R10 software unmute", v, 8'h01);
    send(8'h6E, 1'b1, 1'b0);
    wait_ticks(2);
    reg_read(2'd2, v); check("R10 load after unmute", v, 8'h01);
    reg_read(2'd1, v); check("R10 data after unmute", v, 8'h6E);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule